// File: doc/BRIEF.md
# Half-Bridge Capable PWM Generator

This block produces a pulse-width modulated waveform on one pin or on a complementary pair of pins. Its time base is a count of prescale ticks: an 8-bit period counter forms the upper part, and a 2-bit sub-count, advanced by every tick, forms the lower part. Together they give a 10-bit position within the period. The period counter runs from zero up to a programmed period value and then restarts. At each restart the output goes active. The output goes inactive once the 10-bit position reaches the duty value that was captured at the start of that period.

Software writes four things through a simple register port: the period, a duty buffer, and one control word. The control word holds the enable, the output arrangement and the two polarity bits. The duty buffer is copied into a hidden working copy only at a period restart, so a duty write never alters the pulse already in progress. After the block is enabled it stays idle for one full period, so the first pulse it produces is complete. The output enables tell the surrounding pad logic which pins this block currently owns. A pin whose enable is low is left to other functions.

Top module: `pwm_hbridge`

## Requirements
- R1: After reset the block is disabled, both output enables are low, both outputs are low, the counters are zero and the working duty copy is zero.
- R2: The counters advance only on cycles where `preTick` is high. One period lasts (period+1)*4 ticks, and the period counter restarts after its tick with sub-count 3 in which the period counter is at or above the period register.
- R3: At each period restart the working duty copy takes the value of the duty buffer, and the raw output becomes active unless that value is zero.
- R4: The raw output stays active for exactly duty ticks of the period. A duty of zero gives no active tick, and a duty of (period+1)*4 or more gives an output that is active for the whole period.
- R5: A duty write never changes the working copy between restarts. A new duty value first shapes the pulse of the period that begins after the write.
- R6: Mode 00 (control bits 2:1) is single output. `oeA` is high, `oeB` is low and `outB` is low.
- R7: After enable (control bit 0 set while the block was disabled), both outputs hold their inactive level for the first full period, and the first pulse starts at the first restart.
- R8: Mode 10 is half-bridge. Both enables are high, and while the waveform runs the raw B output is the complement of raw A. Before the first restart both raw outputs are inactive.
- R9: Control bit 3 inverts pin A and control bit 4 inverts pin B, so each pin can be active-high (bit 0) or active-low (bit 1). In single mode the B polarity bit has no effect.
- R10: Writing a control word with bit 0 clear, or with mode 01 or 11, drives both output enables low and both outputs low. Writes to address 0 set the period (bits 7:0), address 1 the duty buffer (bits 9:0), and address 2 the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 period, 1 duty buffer, 2 control |
| wrData | input | 10 | Write data |
| preTick | input | 1 | Prescale tick that advances the time base |
| outA | output | 1 | Primary PWM pin |
| outB | output | 1 | Complementary PWM pin (half-bridge only) |
| oeA | output | 1 | Output enable for pin A |
| oeB | output | 1 | Output enable for pin B |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running period. The pulse then in flight must keep its old width, and the next pulse must take the new width. The bench reaches it by counting cycles from the enable write. It issues the new duty a few cycles after the first restart and measures the active time of two consecutive periods against the old and new values. Slow tick rates and duty values above the full period are checked by counting active cycles over whole periods. Counting whole periods also exposes an off-by-one at the restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_HALF   = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTime;   // hold time base at zero
    logic stepSub;   // advance sub-count
    logic stepTmr;   // advance period counter
    logic wrapTmr;   // period restart: clear counter, latch duty
  } tbStrobe_t;

endpackage

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [TMR_W+SUB_W-1:0]  wrData,
  input  tbStrobe_t               strobe,
  output logic                    tmrAtPeriod,
  output logic                    subAtMax,
  output logic                    dutyActive
);

  localparam int BASE_W = TMR_W + SUB_W;

  logic [TMR_W-1:0]  periodReg;
  logic [BASE_W-1:0] dutyBuf;
  logic [BASE_W-1:0] dutySlave;
  logic [TMR_W-1:0]  tmrCnt;
  logic [SUB_W-1:0]  subCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      dutyBuf   <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_PERIOD) periodReg <= wrData[TMR_W-1:0];
      if (wrAddr == ADDR_DUTY)   dutyBuf   <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (strobe.clrTime) begin
      subCnt <= '0;
    end else if (strobe.stepSub) begin
      subCnt <= subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (strobe.clrTime || strobe.wrapTmr) begin
      tmrCnt <= '0;
    end else if (strobe.stepTmr) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutySlave <= '0;
    end else if (strobe.wrapTmr) begin
      dutySlave <= dutyBuf;
    end
  end

  always_comb begin
    tmrAtPeriod = (tmrCnt >= periodReg);
    subAtMax    = (subCnt == {SUB_W{1'b1}});
    dutyActive  = ({tmrCnt, subCnt} < dutySlave);
  end

  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrapTmr |=> (tmrCnt == '0 && subCnt == '0)); // R3

  AST_SLAVE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrapTmr |=> (dutySlave == $past(dutyBuf))); // R3

  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrapTmr |=> $stable(dutySlave)); // R5

endmodule

// File: rtl/pwm_control.sv
module pwm_control
  import pwm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              preTick,
  input  logic              tmrAtPeriod,
  input  logic              subAtMax,
  input  logic              dutyActive,
  output tbStrobe_t         strobe,
  output logic              rawA,
  output logic              rawB,
  output logic              oeA,
  output logic              oeB,
  output logic              polA,
  output logic              polB
);

  logic       enable;
  logic [1:0] mode;
  logic       running;
  logic       halfMode;
  logic       validMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      mode   <= MODE_SINGLE;
      polA   <= 1'b0;
      polB   <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_CTRL) begin
      enable <= wrData[0];
      mode   <= wrData[2:1];
      polA   <= wrData[3];
      polB   <= wrData[4];
    end
  end

  always_comb begin
    strobe.clrTime = !enable;
    strobe.stepSub = enable && preTick;
    strobe.stepTmr = enable && preTick && subAtMax && !tmrAtPeriod;
    strobe.wrapTmr = enable && preTick && subAtMax && tmrAtPeriod;
  end

  // waveform starts only at the first restart after enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
    end else if (strobe.wrapTmr) begin
      running <= 1'b1;
    end
  end

  always_comb begin
    halfMode  = (mode == MODE_HALF);
    validMode = halfMode || (mode == MODE_SINGLE);
    oeA       = enable && validMode;
    oeB       = enable && halfMode;
    rawA      = running && dutyActive;
    rawB      = running && halfMode && !dutyActive;
  end

  AST_RUN_FROM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(strobe.wrapTmr)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrTime, strobe.stepTmr, strobe.wrapTmr})); // R2

endmodule

// File: rtl/pwm_hbridge.sv
module pwm_hbridge
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int BASE_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BASE_W-1:0] wrData,
  input  logic              preTick,
  output logic              outA,
  output logic              outB,
  output logic              oeA,
  output logic              oeB
);

  tbStrobe_t strobe;
  logic tmrAtPeriod, subAtMax, dutyActive;
  logic rawA, rawB, polA, polB;

  pwm_datapath #(.TMR_W(TMR_W), .SUB_W(SUB_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .tmrAtPeriod(tmrAtPeriod), .subAtMax(subAtMax),
    .dutyActive(dutyActive)
  );

  pwm_control #(.DATA_W(BASE_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .preTick(preTick), .tmrAtPeriod(tmrAtPeriod), .subAtMax(subAtMax),
    .dutyActive(dutyActive), .strobe(strobe), .rawA(rawA), .rawB(rawB),
    .oeA(oeA), .oeB(oeB), .polA(polA), .polB(polB)
  );

  always_comb begin
    outA = oeA && (rawA ^ polA);
    outB = oeB && (rawB ^ polB);
  end

  AST_HALF_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    oeB |-> !((outA ^ polA) && (outB ^ polB))); // R8

endmodule

// File: tb/sim_pwm_hbridge.sv
module sim_pwm_hbridge;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic       preTick = 1'b0;
  logic       outA, outB, oeA, oeB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwm_hbridge u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .preTick(preTick), .outA(outA), .outB(outB), .oeA(oeA), .oeB(oeB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    preTick = 1'b0;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // enable a waveform and measure the idle period and the first full period
  task automatic runWave(input int per, input int duty, input bit half,
                         input bit pa, input bit pb, input int every, input string tag);
    int full, nCyc, expAct, actCnt, idleBad, compBad;
    bit firstAct;
    full = (per + 1) * 4;
    nCyc = full * every;
    expAct = ((duty >= full) ? full : duty) * every;
    actCnt = 0; idleBad = 0; compBad = 0; firstAct = 1'b0;
    wrReg(2'd2, 10'd0);
    wrReg(2'd0, 10'(per));
    wrReg(2'd1, 10'(duty));
    wrReg(2'd2, {5'd0, pb, pa, half, 1'b0, 1'b1});
    for (int k = 1; k < 2 * nCyc; k++) begin
      preTick = (k % every == 0);
      @(negedge clk);
      if (k < nCyc) begin
        if (outA != pa) idleBad++;                        // R7 R9
        if (half && outB != pb) idleBad++;
      end else begin
        if (k == nCyc) firstAct = outA ^ pa;
        actCnt += int'(outA ^ pa);
        if (half) begin
          if ((outB ^ pb) == (outA ^ pa)) compBad++;      // R8
        end else begin
          if (outB != 1'b0 || oeB != 1'b0) compBad++;     // R6
        end
      end
    end
    preTick = 1'b0;
    check(idleBad == 0, {"R7 idle first period ", tag}, idleBad, 0);
    check(firstAct == (duty != 0), {"R3 active at restart ", tag}, int'(firstAct), int'(duty != 0));
    check(actCnt == expAct, {"R4 active length ", tag}, actCnt, expAct);
    check(compBad == 0, {half ? "R8 complement " : "R6 single B quiet ", tag}, compBad, 0);
    check(oeA == 1'b1 && oeB == half, {"R10 enables ", tag}, int'({oeA, oeB}), int'({1'b1, half}));
  endtask

  task automatic testReset();
    @(negedge clk);
    check(oeA == 0 && oeB == 0, "R1 reset enables", int'({oeA, oeB}), 0);
    check(outA == 0 && outB == 0, "R1 reset outputs", int'({outA, outB}), 0);
  endtask

  task automatic testSingle();
    runWave(9, 13, 1'b0, 1'b0, 1'b0, 1, "single d13");
    runWave(9, 0, 1'b0, 1'b0, 1'b0, 1, "single d0");
    runWave(9, 50, 1'b0, 1'b0, 1'b0, 1, "single over");
    runWave(3, 7, 1'b0, 1'b0, 1'b1, 1, "single polB ignored R9");
  endtask

  task automatic testTick();
    runWave(2, 5, 1'b0, 1'b0, 1'b0, 3, "R2 tick every 3");
  endtask

  task automatic testHalf();
    runWave(5, 9, 1'b1, 1'b0, 1'b0, 1, "half");
    runWave(5, 9, 1'b1, 1'b1, 1'b0, 1, "half R9 polA low");
    runWave(4, 11, 1'b1, 1'b1, 1'b1, 2, "half R9 both low");
  endtask

  // duty written mid-period: current pulse keeps old width
  task automatic testDoubleBuffer();
    int full, c1, c2;
    full = 20;
    c1 = 0; c2 = 0;
    wrReg(2'd2, 10'd0);
    wrReg(2'd0, 10'd4);
    wrReg(2'd1, 10'd6);
    wrReg(2'd2, 10'b0_0001);
    for (int k = 1; k < 3 * full; k++) begin
      preTick = 1'b1;
      wrEn = (k == full + 2);
      wrAddr = 2'd1;
      wrData = 10'd15;
      @(negedge clk);
      if (k >= full && k < 2 * full) c1 += int'(outA);
      if (k >= 2 * full) c2 += int'(outA);
    end
    wrEn = 1'b0; preTick = 1'b0;
    check(c1 == 6, "R5 current pulse unchanged", c1, 6);
    check(c2 == 15, "R5 next pulse new duty", c2, 15);
  endtask

  task automatic testRelease();
    runWave(2, 3, 1'b1, 1'b1, 1'b1, 1, "pre-release");
    wrReg(2'd2, 10'd0);
    @(negedge clk);
    check(oeA == 0 && oeB == 0 && outA == 0 && outB == 0, "R10 cleared control releases",
          int'({oeA, oeB, outA, outB}), 0);
    wrReg(2'd2, 10'b0_0011);
    for (int k = 0; k < 20; k++) begin
      preTick = 1'b1;
      @(negedge clk);
    end
    preTick = 1'b0;
    check(oeA == 0 && oeB == 0 && outA == 0 && outB == 0, "R10 mode 01 releases",
          int'({oeA, oeB, outA, outB}), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testSingle();
    testTick();
    testHalf();
    testDoubleBuffer();
    testRelease();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule